// File: doc/BRIEF.md
# Pixel Matrix Hit Capture and Serial Readout

This block is the digital periphery of a small hybrid pixel matrix with two columns of 65 cells. Each cell receives one comparator output from the analog front end. The block samples that output into the clock domain and records a hit when the comparator moves to the active level while the strobe is high. A single polarity input chooses which level is active, so the front end may collect either sign of charge.

Each cell also holds two configuration bits: a test bit and a mask bit. The test bit drives that cell's injection-enable output. The mask bit keeps the cell from ever recording a hit. Both bits are shifted in through one configuration chain per column and become effective on a load pulse.

Recorded hits stay in the cells until they are read out. For readout, the hit registers of each column form a shift register. The registers present one bit per column per accepted beat, cell 0 first, on a valid/ready stream that is shared by both columns.

Top module: `pixmat_periph`

## Requirements
- R1: After reset, every `inj_en` bit, `ro_valid` and `ro_done` are 0, and every stored hit and configuration bit is 0.
- R2: On each `cfg_shift` cycle a column's chain moves one place toward cell 0 and takes `cfg_sdi` in at its top. After 130 shifts, the first bit shifted in is the test bit of cell 0, the second is the mask bit of cell 0, the third is the test bit of cell 1, and so on. `inj_en` changes only on a `cfg_load` cycle, and then equals the test bits, with `inj_en[c*65+r]` belonging to column c, cell r.
- R3: A comparator change applied before clock edge t is evaluated at edge t+2. It is recorded if `strobe` is high in the cycle that ends at that edge, and not if the strobe is high only one cycle earlier or one cycle later.
- R4: A change to the inactive level, or any change while `strobe` is low, records nothing.
- R5: `hit_pol` = 1 makes a 0-to-1 change of `comp_in` a hit; `hit_pol` = 0 makes a 1-to-0 change a hit.
- R6: A cell whose mask bit is 1 never records a hit.
- R7: Once a cell holds a hit, further comparator changes leave it at 1 until it is read out or cleared.
- R8: A `ro_start` pulse while idle raises `ro_valid`. `ro_sdo[c]` then shows column c, cell k on beat k, for k = 0 to 64. A beat completes on a clock edge where `ro_valid` and `ro_ready` are both 1. While `ro_ready` is 0, `ro_valid` and `ro_sdo` hold.
- R9: After the 65th completed beat, `ro_valid` is 0 and `ro_done` is 1. `ro_done` returns to 0 on the next readout start or on `clr`.
- R10: Readout shifts zeros in behind the data, so a second readout with no new hits returns all zeros. A `clr` pulse zeros all stored hits, aborts any readout and clears `ro_done`.
- R11: While `ro_valid` is 1, no hit is recorded and `ro_start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 130 | Comparator outputs, bit c*65+r is column c cell r |
| hit_pol | input | 1 | 1: rising change is a hit, 0: falling change is a hit |
| strobe | input | 1 | Capture window enable |
| cfg_sdi | input | 2 | Serial configuration data, one bit per column |
| cfg_shift | input | 1 | Advance both configuration chains |
| cfg_load | input | 1 | Copy chain contents into the test and mask bits |
| inj_en | output | 130 | Injection enable per cell (test bits) |
| clr | input | 1 | Zero all hits, abort readout, clear done |
| ro_start | input | 1 | Begin a readout sequence when idle |
| ro_valid | output | 1 | Readout beat available |
| ro_ready | input | 1 | Consumer accepts the current beat |
| ro_sdo | output | 2 | Readout bit of each column for the current beat |
| ro_done | output | 1 | Last beat of the readout has been accepted |

## Verification
The hardest behaviour to reach from the ports is the exact capture window. The comparator change must line up with the strobe at a single clock edge two synchronizer stages later. The bench drives three cells with one-cycle strobe pulses placed early, on time and late relative to their changes, and expects only the on-time cell in the readout. The second hard case is comparator activity during an active readout: a concurrent process toggles the comparators with the strobe high while beats are being drained under random back-pressure, and a following readout must return all zeros.

// File: rtl/pixmat_pkg.sv
package pixmat_pkg;
  typedef enum logic {
    RO_IDLE  = 1'b0,
    RO_SHIFT = 1'b1
  } ro_state_t;

  // position of a cell's two bits inside its column configuration chain
  function automatic int cfg_test_pos(input int row);
    return 2 * row;
  endfunction

  function automatic int cfg_mask_pos(input int row);
    return 2 * row + 1;
  endfunction
endpackage

// File: rtl/pixmat_sync.sv
module pixmat_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '0;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pixmat_cfg_col.sv
module pixmat_cfg_col
  import pixmat_pkg::*;
#(
  parameter int NROW = 65
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sdi,
  input  logic            shift,
  input  logic            load,
  output logic [NROW-1:0] test_q,
  output logic [NROW-1:0] mask_q
);
  localparam int CHAIN = 2 * NROW;

  logic [CHAIN-1:0] chain;
  logic [NROW-1:0]  test_d, mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     chain <= '0;
    else if (shift) chain <= {sdi, chain[CHAIN-1:1]};
  end

  for (genvar r = 0; r < NROW; r++) begin : g_split
    assign test_d[r] = chain[cfg_test_pos(r)];
    assign mask_d[r] = chain[cfg_mask_pos(r)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      test_q <= test_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/pixmat_col.sv
module pixmat_col #(
  parameter int NROW = 65
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] comp_s,
  input  logic            hit_pol,
  input  logic            strobe,
  input  logic [NROW-1:0] mask,
  input  logic            cap_en,
  input  logic            clr,
  input  logic            shift,
  output logic            sdo
);
  logic [NROW-1:0] prev;
  logic [NROW-1:0] data;
  logic [NROW-1:0] hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= comp_s;
  end

  for (genvar r = 0; r < NROW; r++) begin : g_cell
    logic changed;
    logic to_active;
    assign changed    = comp_s[r] ^ prev[r];
    assign to_active  = (comp_s[r] == hit_pol);
    assign hit_now[r] = changed & to_active & strobe & cap_en & ~mask[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data <= '0;
    else if (clr)   data <= '0;
    else if (shift) data <= {1'b0, data[NROW-1:1]};
    else            data <= data | hit_now;
  end

  assign sdo = data[0];
endmodule

// File: rtl/pixmat_ro_ctrl.sv
module pixmat_ro_ctrl
  import pixmat_pkg::*;
#(
  parameter int NROW = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  input  logic ready,
  output logic valid,
  output logic done,
  output logic shift
);
  localparam int CW = (NROW > 1) ? $clog2(NROW) : 1;
  localparam logic [CW-1:0] LAST = CW'(NROW - 1);

  ro_state_t      state;
  logic [CW-1:0]  cnt;

  assign valid = (state == RO_SHIFT);
  assign shift = valid & ready & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RO_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (clr) begin
      state <= RO_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else if (state == RO_IDLE) begin
      if (start) begin
        state <= RO_SHIFT;
        cnt   <= '0;
        done  <= 1'b0;
      end
    end else if (shift) begin
      if (cnt == LAST) begin
        state <= RO_IDLE;
        cnt   <= '0;
        done  <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixmat_periph.sv
module pixmat_periph #(
  parameter int NCOL        = 2,
  parameter int NROW        = 65,
  parameter int SYNC_STAGES = 2,
  localparam int NCELL      = NCOL * NROW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] comp_in,
  input  logic             hit_pol,
  input  logic             strobe,
  input  logic [NCOL-1:0]  cfg_sdi,
  input  logic             cfg_shift,
  input  logic             cfg_load,
  output logic [NCELL-1:0] inj_en,
  input  logic             clr,
  input  logic             ro_start,
  output logic             ro_valid,
  input  logic             ro_ready,
  output logic [NCOL-1:0]  ro_sdo,
  output logic             ro_done
);
  logic [NCELL-1:0] comp_s;
  logic             ro_shift;

  pixmat_sync #(.W(NCELL), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comp_in),
    .q     (comp_s)
  );

  pixmat_ro_ctrl #(.NROW(NROW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ro_start),
    .clr   (clr),
    .ready (ro_ready),
    .valid (ro_valid),
    .done  (ro_done),
    .shift (ro_shift)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [NROW-1:0] test_q, mask_q;

    pixmat_cfg_col #(.NROW(NROW)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .sdi    (cfg_sdi[c]),
      .shift  (cfg_shift),
      .load   (cfg_load),
      .test_q (test_q),
      .mask_q (mask_q)
    );

    pixmat_col #(.NROW(NROW)) u_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .comp_s  (comp_s[c*NROW +: NROW]),
      .hit_pol (hit_pol),
      .strobe  (strobe),
      .mask    (mask_q),
      .cap_en  (~ro_valid),
      .clr     (clr),
      .shift   (ro_shift),
      .sdo     (ro_sdo[c])
    );

    assign inj_en[c*NROW +: NROW] = test_q;
  end
endmodule

// File: rtl/pixmat_periph_chk.sv
module pixmat_periph_chk #(
  parameter int NCOL  = 2,
  parameter int NROW  = 65,
  localparam int NCELL = NCOL * NROW,
  localparam int BW    = $clog2(NROW + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic [NCELL-1:0] inj_en,
  input logic             clr,
  input logic             ro_start,
  input logic             ro_valid,
  input logic             ro_ready,
  input logic [NCOL-1:0]  ro_sdo,
  input logic             ro_done
);
  logic [BW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    beats <= '0;
    else if (clr || !ro_valid)     beats <= '0;
    else if (ro_ready)             beats <= beats + 1'b1;
  end

  // R2: test bits reach inj_en only through a load
  p_inj_needs_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(inj_en));

  // R8: back-pressure holds the beat
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid && !ro_ready && !clr |=> ro_valid && $stable(ro_sdo));

  // R8: never more beats than cells in a column
  p_beat_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid |-> beats < BW'(NROW));

  // R9: done follows the last accepted beat
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid && ro_ready && !clr && beats == BW'(NROW - 1) |=> ro_done && !ro_valid);

  // R9: done and valid never overlap
  p_done_excl_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid |-> !ro_done);

  // R11: readout continues regardless of ro_start until its last beat
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ro_valid && !clr && !(ro_ready && beats == BW'(NROW - 1)) |=> ro_valid);

  // R10: clr aborts readout and clears done
  p_clr_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ro_valid && !ro_done);
endmodule

bind pixmat_periph pixmat_periph_chk #(.NCOL(NCOL), .NROW(NROW)) u_chk (.*);

// File: tb/pixmat_periph_test.sv
`timescale 1ns/1ps
module pixmat_periph_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL  = 2;
  localparam int NROW  = 65;
  localparam int NCELL = NCOL * NROW;

  logic             clk = 0;
  logic             rst_n = 0;
  logic [NCELL-1:0] comp_in = '0;
  logic             hit_pol = 1'b1;
  logic             strobe = 1'b0;
  logic [NCOL-1:0]  cfg_sdi = '0;
  logic             cfg_shift = 1'b0;
  logic             cfg_load = 1'b0;
  logic [NCELL-1:0] inj_en;
  logic             clr = 1'b0;
  logic             ro_start = 1'b0;
  logic             ro_valid;
  logic             ro_ready = 1'b0;
  logic [NCOL-1:0]  ro_sdo;
  logic             ro_done;

  pixmat_periph #(.NCOL(NCOL), .NROW(NROW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit tst  [NCOL][NROW];
  bit msk  [NCOL][NROW];
  bit expd [NCOL][NROW];
  logic [NCELL-1:0] inj_model = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_hit(input bit old_v, input bit new_v, input bit pol,
                                input bit masked, input bit strobe_on);
    return (old_v != new_v) && (new_v == pol) && !masked && strobe_on;
  endfunction

  function automatic logic [NCELL-1:0] test_vec();
    logic [NCELL-1:0] v;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) v[c*NROW + r] = tst[c][r];
    return v;
  endfunction

  task automatic clear_model();
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) expd[c][r] = 1'b0;
  endtask

  task automatic apply_cfg();
    for (int i = 0; i < 2*NROW; i++) begin
      for (int c = 0; c < NCOL; c++)
        cfg_sdi[c] = (i % 2 == 1) ? msk[c][i/2] : tst[c][i/2];
      cfg_shift = 1'b1;
      @(negedge clk);
    end
    cfg_shift = 1'b0;
    chk(inj_en == inj_model, "R2", "inj_en changed without load", 0, 0);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    inj_model = test_vec();
    chk(inj_en == inj_model, "R2", "inj_en after load equals test bits",
        longint'(inj_en[63:0]), longint'(inj_model[63:0]));
  endtask

  task automatic rand_cfg(input int mask_pct);
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) begin
        tst[c][r] = $urandom_range(0, 1);
        msk[c][r] = ($urandom_range(0, 99) < mask_pct);
      end
  endtask

  // toggle comparators for ncyc cycles; model records hits when strobe_on
  task automatic toggle_phase(input int ncyc, input bit strobe_on, input bit model_on);
    for (int k = 0; k < ncyc; k++) begin
      for (int c = 0; c < NCOL; c++)
        for (int r = 0; r < NROW; r++)
          if ($urandom_range(0, 3) == 0) begin
            bit o = comp_in[c*NROW + r];
            comp_in[c*NROW + r] = ~o;
            if (model_on && is_hit(o, ~o, hit_pol, msk[c][r], strobe_on))
              expd[c][r] = 1'b1;
          end
      @(negedge clk);
    end
  endtask

  task automatic do_readout(input string tag, input bit mid_start);
    int k = 0;
    int guard = 0;
    @(negedge clk);
    ro_start = 1'b1;
    @(negedge clk);
    ro_start = 1'b0;
    chk(ro_valid == 1'b1 && ro_done == 1'b0, "R9",
        "valid up and done cleared after start", {ro_valid, ro_done}, 2);
    while (k < NROW && guard < 1000) begin
      bit rdy;
      guard++;
      if (!ro_valid) begin
        chk(1'b0, "R8", "valid dropped before last beat", k, NROW);
        break;
      end
      for (int c = 0; c < NCOL; c++)
        chk(ro_sdo[c] == expd[c][k], tag, $sformatf("beat %0d col %0d", k, c),
            ro_sdo[c], expd[c][k]);
      rdy = ($urandom_range(0, 3) != 0);
      ro_start = (mid_start && k == 10);
      ro_ready = rdy;
      if (rdy) k++;
      @(negedge clk);
    end
    ro_ready = 1'b0;
    ro_start = 1'b0;
    chk(ro_valid == 1'b0 && ro_done == 1'b1, "R9",
        "after 65th beat valid low, done high", {ro_valid, ro_done}, 1);
    clear_model();
  endtask

  task automatic rand_trial();
    rand_cfg(25);
    apply_cfg();
    hit_pol = $urandom_range(0, 1);
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    toggle_phase(6, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
    do_readout("R3 R5 R6 R7", 1'b0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h51ed));
    clear_model();
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) begin tst[c][r] = 0; msk[c][r] = 0; end
    repeat (3) @(negedge clk);
    chk(inj_en == '0 && ro_valid == 0 && ro_done == 0, "R1", "outputs in reset",
        {ro_valid, ro_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(inj_en == '0 && ro_valid == 0 && ro_done == 0, "R1", "outputs after reset",
        {ro_valid, ro_done}, 0);
    do_readout("R1", 1'b0);

    // R3 window boundaries, all unmasked, rising polarity
    apply_cfg();
    hit_pol = 1'b1;
    comp_in = '0;
    repeat (4) @(negedge clk);
    comp_in[5] = 1'b1;                          // on-time window
    @(negedge clk); @(negedge clk);
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    expd[0][5] = 1'b1;
    repeat (3) @(negedge clk);
    comp_in[NROW + 7] = 1'b1;                   // window one cycle early
    @(negedge clk);
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    repeat (4) @(negedge clk);
    comp_in[NROW + 9] = 1'b1;                   // window one cycle late
    @(negedge clk); @(negedge clk); @(negedge clk);
    strobe = 1'b1; @(negedge clk); strobe = 1'b0;
    repeat (3) @(negedge clk);
    do_readout("R3", 1'b0);

    // R4: toggles with strobe low record nothing
    toggle_phase(8, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    do_readout("R4", 1'b0);

    // R5 falling polarity, R7 sticky hit on cell 0 of column 1
    hit_pol = 1'b0;
    comp_in = '1;
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    comp_in[NROW] = 1'b0; @(negedge clk);
    comp_in[NROW] = 1'b1; @(negedge clk);
    comp_in[NROW] = 1'b0; @(negedge clk);
    comp_in[NROW] = 1'b1;
    comp_in[3] = 1'b0;
    expd[1][0] = 1'b1; expd[0][3] = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    do_readout("R5 R7", 1'b1);                 // mid-readout start also checks R11

    // R10: second readout is empty
    do_readout("R10", 1'b0);

    // R10: clr zeros hits and done
    hit_pol = 1'b1;
    comp_in = '0;
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    toggle_phase(4, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(ro_done == 1'b0, "R10", "done cleared by clr", ro_done, 0);
    do_readout("R10", 1'b0);

    // R11: comparator activity during readout is not captured
    hit_pol = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    comp_in = '0; @(negedge clk);
    comp_in = '1; expd[0][0] = 1'b0;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++) expd[c][r] = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    comp_in = '0;
    repeat (4) @(negedge clk);
    fork
      do_readout("R11", 1'b0);
      begin
        repeat (3) @(negedge clk);
        strobe = 1'b1;
        toggle_phase(12, 1'b1, 1'b0);
        strobe = 1'b0;
      end
    join
    do_readout("R11", 1'b0);

    // R6 directed: fully masked column 0 sees no hits
    for (int r = 0; r < NROW; r++) begin msk[0][r] = 1; msk[1][r] = 0; end
    apply_cfg();
    hit_pol = 1'b1;
    comp_in = '0;
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    comp_in = '1;
    for (int r = 0; r < NROW; r++) expd[1][r] = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    do_readout("R6", 1'b0);

    for (int t = 0; t < 16; t++) rand_trial();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule